// File: doc/BRIEF.md
# RTC Sub-Second Shift Unit

This block divides a prescaled real-time-clock tick down to whole seconds with a down-counting sub-second counter. Each time the counter reaches zero it reloads from a programmable reload value and reports one elapsed second. One second therefore spans `reload + 1` ticks.

The block also performs an atomic time shift. A shift write carries a 15-bit fraction and an add-second flag. The write is held as pending. On the next tick the fraction is added to the counter during its normal step, which retards the time by `fraction / (reload + 1)` seconds. When the add-second flag is also set, one extra second is reported in the same cycle. The net effect is then an advance of `1 - fraction / (reload + 1)` seconds.

A shadow-synchronised flag tells the consumer whether the sub-second count seen downstream reflects the latest shift. The flag drops on every accepted shift and comes back one tick after the shift has been applied. The calendar, and any register bus that writes the shift fields, lie outside this block.

Top module: `subsec_shift_unit`

## Requirements
- R1: After reset `subsec_cnt` is 0, `sec_step` is 0, `shift_pend` is 0 and `shadow_sync` is 0.
- R2: On a cycle with `tick` high, no pending shift and a nonzero count, the count drops by one and `sec_step` is 0 on the following cycle.
- R3: On a cycle with `tick` high and a count of zero, the count loads `reload_val` and `sec_step` reports at least 1 on the following cycle.
- R4: A `shift_wr` while no shift is pending is accepted. On the next cycle `shift_pend` is 1 and `shadow_sync` is 0.
- R5: A `shift_wr` while a shift is pending is ignored. The shift that is later applied uses the fraction and flag of the first, accepted write.
- R6: The first `tick` after an accepted write applies the shift. The new count is the normal step (reload value at zero, else count minus one) plus the fraction, and `shift_pend` clears on the next cycle.
- R7: `sec_step` (2 bits) gives the number of seconds elapsed in the tick just taken. That is the zero-wrap second plus one more when the applied shift carries the add-second flag, so it reaches 2 when both occur together.
- R8: The count is 16 bits wide. A shifted sum that would exceed 65535 saturates at 65535.
- R9: `shadow_sync` is set by the tick that follows the tick that applied a shift, and by the first tick after reset. An accepted write in that same cycle takes priority and keeps the flag clear.
- R10: On cycles with `tick` low, the count and `shift_pend` hold their values, and `sec_step` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled tick enable, one cycle per count step |
| reload_val | input | 15 | Value loaded when the count wraps at zero |
| shift_wr | input | 1 | Shift write strobe |
| shift_add_sec | input | 1 | Shift field: report one extra second |
| shift_frac | input | 15 | Shift field: fraction added to the count |
| sec_step | output | 2 | Seconds elapsed in the last tick (0, 1 or 2) |
| subsec_cnt | output | 16 | Current sub-second down-count |
| shift_pend | output | 1 | A shift write is waiting for the next tick |
| shadow_sync | output | 1 | Downstream copy reflects the latest shift |

## Verification
Every result is registered. The count, `sec_step` and both flags are due one clock edge after the cycle that presented `tick` or `shift_wr`. The applied shift shows up at the first tick edge after the accepted write, and the restored synchronised flag follows one tick after that. The bench drives inputs on the falling edge and samples 2 ns after each rising edge. Its arithmetic model advances by exactly one edge per driven cycle, so each comparison lands in the cycle the result is due.

// File: rtl/ssu_pkg.sv
`timescale 1ns/1ps
package ssu_pkg;
  parameter int unsigned SSU_FRAC_W = 15;
  parameter int unsigned SSU_CNT_W  = SSU_FRAC_W + 1;
  parameter int unsigned SSU_STEP_W = 2;

  typedef logic [SSU_CNT_W-1:0]  cnt_t;
  typedef logic [SSU_FRAC_W-1:0] frac_t;
  typedef logic [SSU_STEP_W-1:0] step_t;

  // normal countdown step: reload at zero, otherwise decrement
  function automatic cnt_t base_step(input cnt_t c, input frac_t r);
    if (c == '0) return cnt_t'(r);
    return c - cnt_t'(1);
  endfunction

  // count plus fraction, clamped to the counter range
  function automatic cnt_t sat_add(input cnt_t a, input frac_t b);
    logic [SSU_CNT_W:0] s;
    s = {1'b0, a} + (SSU_CNT_W+1)'(b);
    if (s[SSU_CNT_W]) return '1;
    return s[SSU_CNT_W-1:0];
  endfunction

  // seconds elapsed in one tick
  function automatic step_t sec_count(input logic wrapped, input logic extra);
    return step_t'(wrapped) + step_t'(extra);
  endfunction
endpackage

// File: rtl/ssu_shift_ctrl.sv
`timescale 1ns/1ps
module ssu_shift_ctrl
  import ssu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  shift_wr,
  input  logic  shift_add_sec,
  input  frac_t shift_frac,
  output logic  pend,
  output frac_t hold_frac,
  output logic  hold_add,
  output logic  accept,
  output logic  apply,
  output logic  sync_ok
);
  logic sync_wait;
  logic sync_set;

  assign accept   = shift_wr && !pend;
  assign apply    = tick && pend;
  assign sync_set = tick && sync_wait && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      hold_frac <= '0;
      hold_add  <= 1'b0;
    end else if (accept) begin
      pend      <= 1'b1;
      hold_frac <= shift_frac;
      hold_add  <= shift_add_sec;
    end else if (apply) begin
      pend      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_ok   <= 1'b0;
      sync_wait <= 1'b1;
    end else if (accept) begin
      sync_ok   <= 1'b0;
      sync_wait <= 1'b0;
    end else if (apply) begin
      sync_wait <= 1'b1;
    end else if (sync_set) begin
      sync_ok   <= 1'b1;
      sync_wait <= 1'b0;
    end
  end
endmodule

// File: rtl/ssu_prescaler.sv
`timescale 1ns/1ps
module ssu_prescaler
  import ssu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  frac_t reload,
  input  logic  apply,
  input  frac_t frac,
  input  logic  add_sec,
  output cnt_t  cnt,
  output step_t sec_step,
  output logic  wrap_evt
);
  cnt_t base;
  cnt_t nxt;

  assign wrap_evt = tick && (cnt == '0);
  assign base     = base_step(cnt, reload);
  assign nxt      = apply ? sat_add(base, frac) : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sec_step <= '0;
    end else if (tick) begin
      cnt      <= nxt;
      sec_step <= sec_count(cnt == '0, apply && add_sec);
    end else begin
      sec_step <= '0;
    end
  end
endmodule

// File: rtl/subsec_shift_unit.sv
`timescale 1ns/1ps
module subsec_shift_unit
  import ssu_pkg::*;
#(
  parameter int unsigned FRAC_W = ssu_pkg::SSU_FRAC_W,
  localparam int unsigned CNT_W = FRAC_W + 1,
  localparam int unsigned STEP_W = ssu_pkg::SSU_STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FRAC_W-1:0] reload_val,
  input  logic              shift_wr,
  input  logic              shift_add_sec,
  input  logic [FRAC_W-1:0] shift_frac,
  output logic [STEP_W-1:0] sec_step,
  output logic [CNT_W-1:0]  subsec_cnt,
  output logic              shift_pend,
  output logic              shadow_sync
);
  frac_t hold_frac;
  logic  hold_add;
  logic  wr_accept;
  logic  shift_apply;
  logic  wrap_evt;

  ssu_shift_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .shift_wr(shift_wr), .shift_add_sec(shift_add_sec), .shift_frac(shift_frac),
    .pend(shift_pend), .hold_frac(hold_frac), .hold_add(hold_add),
    .accept(wr_accept), .apply(shift_apply), .sync_ok(shadow_sync)
  );

  ssu_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_val),
    .apply(shift_apply), .frac(hold_frac), .add_sec(hold_add),
    .cnt(subsec_cnt), .sec_step(sec_step), .wrap_evt(wrap_evt)
  );
endmodule

// File: rtl/ssu_checker.sv
`timescale 1ns/1ps
module ssu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        shift_wr,
  input logic        shift_pend,
  input logic        shadow_sync,
  input logic [1:0]  sec_step,
  input logic [15:0] subsec_cnt,
  input logic [14:0] hold_frac,
  input logic        hold_add,
  input logic        wrap_evt
);
  a_r10_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(subsec_cnt) && sec_step == 2'd0);

  a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
    shift_wr && !shift_pend |=> shift_pend && !shadow_sync);

  a_r5_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    shift_wr && shift_pend |=> $stable(hold_frac) && $stable(hold_add));

  a_r6_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tick && shift_pend |=> !shift_pend);

  a_r3_wrap_second: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> sec_step != 2'd0);

  a_r7_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step != 2'd3);

  a_r9_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shadow_sync) |-> $past(tick) && !shift_pend);
endmodule

bind subsec_shift_unit ssu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .shift_wr(shift_wr),
  .shift_pend(shift_pend), .shadow_sync(shadow_sync), .sec_step(sec_step),
  .subsec_cnt(subsec_cnt), .hold_frac(hold_frac), .hold_add(hold_add),
  .wrap_evt(wrap_evt)
);

// File: tb/sim_subsec_shift_unit.sv
`timescale 1ns/1ps
module sim_subsec_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [14:0] reload_val = '0;
  logic        shift_wr = 1'b0;
  logic        shift_add_sec = 1'b0;
  logic [14:0] shift_frac = '0;
  logic [1:0]  sec_step;
  logic [15:0] subsec_cnt;
  logic        shift_pend;
  logic        shadow_sync;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // arithmetic model state
  int m_cnt = 0, m_step = 0, m_frac = 0;
  bit m_pend = 0, m_add = 0, m_sync = 0, m_wait = 1;

  always #4 clk = ~clk;

  subsec_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload_val(reload_val),
    .shift_wr(shift_wr), .shift_add_sec(shift_add_sec), .shift_frac(shift_frac),
    .sec_step(sec_step), .subsec_cnt(subsec_cnt), .shift_pend(shift_pend),
    .shadow_sync(shadow_sync)
  );

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, subsec_cnt == m_cnt[15:0] && sec_step == m_step[1:0] &&
               shift_pend == m_pend && shadow_sync == m_sync,
          $sformatf("cnt=%0d step=%0d pend=%0d sync=%0d", subsec_cnt, sec_step, shift_pend, shadow_sync),
          $sformatf("cnt=%0d step=%0d pend=%0d sync=%0d", m_cnt, m_step, m_pend, m_sync));
  endtask

  // drive one cycle from a falling edge, update the model at the rising edge, sample after it
  task automatic cyc(input bit t, input bit w, input bit a, input int f, input string tag);
    bit take;
    int s;
    tick = t; shift_wr = w; shift_add_sec = a; shift_frac = f[14:0];
    @(posedge clk);
    take = w && !m_pend;
    s = 0;
    if (t) begin
      int v;
      if (m_cnt == 0) begin v = int'(reload_val); s = 1; end
      else v = m_cnt - 1;
      if (m_pend) begin
        v = v + m_frac;
        if (v > 65535) v = 65535;
        if (m_add) s = s + 1;
      end
      m_cnt = v;
    end
    m_step = s;
    if (take) begin m_sync = 0; m_wait = 0; end
    else if (t && m_pend) m_wait = 1;
    else if (t && m_wait) begin m_sync = 1; m_wait = 0; end
    if (take) begin m_pend = 1; m_frac = f; m_add = a; end
    else if (t && m_pend) m_pend = 0;
    #2;
    compare(tag);
    @(negedge clk);
    tick = 0; shift_wr = 0; shift_add_sec = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", subsec_cnt == 0 && sec_step == 0 && !shift_pend && !shadow_sync,
          $sformatf("cnt=%0d step=%0d pend=%0d sync=%0d", subsec_cnt, sec_step, shift_pend, shadow_sync),
          "all zero");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R10 idle");
    cyc(1, 0, 0, 0, "R3 R9 first tick");

    // countdown and wrap over a sweep of small reload values
    for (int r = 0; r < 7; r++) begin
      reload_val = 15'(r);
      for (int k = 0; k < 2 * (r + 1) + 2; k++) begin
        cyc(1, 0, 0, 0, "R2 R3 countdown");
        if (k % 3 == 0) cyc(0, 0, 0, 0, "R10 gap");
      end
    end

    // shift sweep over fraction, add-second flag and counter phase
    reload_val = 15'd9;
    for (int f = 0; f < 13; f++) begin
      for (int a = 0; a < 2; a++) begin
        for (int p = 0; p < (f % 5); p++) cyc(1, 0, 0, 0, "R2 phase");
        cyc(0, 1, a[0], f, "R4 accept");
        cyc(0, 1, ~a[0], f + 100, "R5 ignored write");
        cyc(0, 0, 0, 0, "R10 pending hold");
        cyc(1, 1, 1, 7, "R5 R6 R7 apply");
        cyc(1, 0, 0, 0, "R9 sync return");
        for (int q = 0; q < 3; q++) cyc(1, 0, 0, 0, "R2 R3 after shift");
      end
    end

    // add-second exactly at wrap: two seconds in one tick
    while (m_cnt != 0) cyc(1, 0, 0, 0, "R2 seek zero");
    cyc(0, 1, 1, 3, "R4 accept at zero");
    cyc(1, 0, 0, 0, "R7 double second");
    check("R7", sec_step == 2'd2, $sformatf("%0d", sec_step), "2");

    // accepted write in the cycle that would restore sync
    cyc(1, 1, 0, 2, "R9 write wins over sync");
    cyc(1, 0, 0, 0, "R6 apply");
    cyc(1, 0, 0, 0, "R9 sync back");
    check("R9", shadow_sync == 1'b1, $sformatf("%0d", shadow_sync), "1");

    // saturation
    reload_val = 15'h7FFF;
    while (m_cnt != 0) cyc(1, 0, 0, 0, "R2 seek zero");
    cyc(1, 0, 0, 0, "R3 load max reload");
    cyc(0, 1, 0, 32767, "R4 accept big");
    cyc(1, 0, 0, 0, "R6 big sum");
    check("R6", subsec_cnt == 16'd65533, $sformatf("%0d", subsec_cnt), "65533");
    cyc(0, 1, 0, 32767, "R4 accept big again");
    cyc(1, 0, 0, 0, "R8 saturate");
    check("R8", subsec_cnt == 16'hFFFF, $sformatf("%0d", subsec_cnt), "65535");
    cyc(1, 0, 0, 0, "R2 after saturation");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule